// File: doc/BRIEF.md
# Display Character Write and Clear Sequencer

This block sits on the host side of a four-digit alphanumeric display that has a parallel load port. A request carrying a 2-bit digit index and a 7-bit character code arrives on a valid/ready handshake. The block places the index and the code on the display's address and data lines and then lowers an active-low write strobe. The time before the strobe, the strobe width and the time after it are each counted in system clock cycles. A separate clear request lowers an active-low clear line for at least one millisecond, which erases the whole character memory of the display.

Each interval is given in nanoseconds as a parameter. The block converts it to cycles from the clock frequency parameter and rounds up. The defaults cover the slowest corner of the display: 10 ns of address setup, 90 ns of strobe width and 40 ns of hold. While any operation runs, the shared ready output stays low. A clear wins over a write that is offered in the same cycle. After each operation the strobes go back high and the address and data lines keep their last values.

Top module: `digit_load_sequencer`

## Requirements
- R1: After reset, req_ready is 1, disp_wr_n and disp_clr_n are 1, and disp_addr and disp_data are 0.
- R2: A write is accepted on a clock edge where wr_valid and req_ready are both 1 and clr_valid is 0. From the next cycle on, disp_addr and disp_data show the request, and disp_wr_n stays high for the setup count of cycles before it goes low.
- R3: For each accepted write, disp_wr_n is low for exactly the strobe count of consecutive cycles. This count covers both the strobe width and the data setup time.
- R4: After disp_wr_n rises, disp_addr and disp_data stay unchanged and req_ready stays low for the hold count of cycles. req_ready then returns to 1.
- R5: An accepted clear drives disp_clr_n low for exactly the clear count of consecutive cycles, starting the cycle after acceptance. req_ready then returns to 1.
- R6: While req_ready is 0, requests are ignored. disp_addr, disp_data and the strobes follow only the operation already running.
- R7: If clr_valid and wr_valid are both 1 on an edge where req_ready is 1, the clear is accepted and the write is not. The write can be accepted after the clear has finished. disp_wr_n and disp_clr_n are never low at the same time.
- R8: While idle, disp_wr_n and disp_clr_n are 1, and disp_addr and disp_data keep the values of the last accepted write.
- R9: Each count equals ceil(interval_ns × CLK_HZ / 10^9), with a minimum of 1. With CLK_HZ = 40 MHz this gives setup 1, strobe 4, hold 2 and clear 40000.
- R10: wr_digit reaches disp_addr[1:0] unchanged, with digit 0 (code 00) being the rightmost digit. wr_char[6:0] reaches disp_data[6:0] unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_digit | input | 2 | Digit index of the write (0 = rightmost) |
| wr_char | input | 7 | Character code of the write |
| clr_valid | input | 1 | Clear request valid |
| req_ready | output | 1 | High when a request can be accepted |
| disp_addr | output | 2 | Digit address lines to the display |
| disp_data | output | 7 | Character data lines to the display |
| disp_wr_n | output | 1 | Active-low write strobe |
| disp_clr_n | output | 1 | Active-low clear line |

## Verification
Every output is registered. Take an acceptance edge where the request is seen. The address and data change right after that edge. The strobe falls after the setup count of further edges. It rises after the strobe count more, and ready returns after the hold count more. After a clear, the clear line falls right after the acceptance edge and rises after the clear count of edges. The bench keeps a behavioural model that counts cycles since acceptance. It compares every output with the model at each falling clock edge, away from the edge where the design updates. Separate run-length counters measure each strobe and each clear pulse against the expected cycle counts.

// File: rtl/dls_pkg.sv
package dls_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_CLEAR
    } dls_state_e;

    // Round an interval in nanoseconds up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(longint unsigned ns, longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/dls_interval.sv
module dls_interval #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // A new interval is only started once the previous one has run out.
    assert_load_expired_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> expired);

endmodule

// File: rtl/dls_pick.sv
module dls_pick (
    input  logic idle,
    input  logic wr_valid,
    input  logic clr_valid,
    output logic take_wr,
    output logic take_clr
);
    // Clear outranks write when both are offered together.
    always_comb begin
        take_clr = idle && clr_valid;
        take_wr  = idle && wr_valid && !clr_valid;
    end
endmodule

// File: rtl/digit_load_sequencer.sv
module digit_load_sequencer #(
    parameter int          ADDR_W        = 2,
    parameter int          DATA_W        = 7,
    parameter longint      CLK_HZ        = 100_000_000,
    parameter longint      ADDR_SETUP_NS = 10,
    parameter longint      STROBE_NS     = 90,
    parameter longint      DATA_SETUP_NS = 50,
    parameter longint      HOLD_NS       = 40,
    parameter longint      CLEAR_NS      = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_digit,
    input  logic [DATA_W-1:0] wr_char,
    input  logic              clr_valid,
    output logic              req_ready,
    output logic [ADDR_W-1:0] disp_addr,
    output logic [DATA_W-1:0] disp_data,
    output logic              disp_wr_n,
    output logic              disp_clr_n
);
    import dls_pkg::*;

    localparam int SETUP_CYC  = ns_to_cycles(ADDR_SETUP_NS, CLK_HZ);
    localparam int STRB_RAW   = ns_to_cycles(STROBE_NS, CLK_HZ);
    localparam int DSET_RAW   = ns_to_cycles(DATA_SETUP_NS, CLK_HZ);
    localparam int STRB_CYC   = (STRB_RAW > DSET_RAW) ? STRB_RAW : DSET_RAW;
    localparam int HOLD_CYC   = ns_to_cycles(HOLD_NS, CLK_HZ);
    localparam int CLR_CYC    = ns_to_cycles(CLEAR_NS, CLK_HZ);
    localparam int MAX_CYC    = (CLR_CYC > STRB_CYC) ? CLR_CYC : STRB_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    typedef struct packed {
        dls_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              wr_n;
        logic              clr_n;
    } seq_t;

    seq_t r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             take_wr, take_clr;
    logic             idle;

    assign idle = (r_q.st == ST_IDLE);

    dls_pick u_pick (
        .idle      (idle),
        .wr_valid  (wr_valid),
        .clr_valid (clr_valid),
        .take_wr   (take_wr),
        .take_clr  (take_clr)
    );

    dls_interval #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (take_clr) begin
                    r_d.st    = ST_CLEAR;
                    r_d.clr_n = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = CNT_W'(CLR_CYC - 1);
                end else if (take_wr) begin
                    r_d.st   = ST_SETUP;
                    r_d.addr = wr_digit;
                    r_d.data = wr_char;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: if (tmr_expired) begin
                r_d.st   = ST_STROBE;
                r_d.wr_n = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(STRB_CYC - 1);
            end
            ST_STROBE: if (tmr_expired) begin
                r_d.st   = ST_HOLD;
                r_d.wr_n = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HOLD_CYC - 1);
            end
            ST_HOLD: if (tmr_expired) begin
                r_d.st = ST_IDLE;
            end
            ST_CLEAR: if (tmr_expired) begin
                r_d.st    = ST_IDLE;
                r_d.clr_n = 1'b1;
            end
            default: begin
                r_d.st    = ST_IDLE;
                r_d.wr_n  = 1'b1;
                r_d.clr_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.data  <= '0;
            r_q.wr_n  <= 1'b1;
            r_q.clr_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = idle;
    assign disp_addr  = r_q.addr;
    assign disp_data  = r_q.data;
    assign disp_wr_n  = r_q.wr_n;
    assign disp_clr_n = r_q.clr_n;

    // Run-length counters used only by the assertions below.
    logic [CNT_W-1:0] wr_run_d, wr_run_q, clr_run_d, clr_run_q;

    always_comb begin
        wr_run_d  = disp_wr_n  ? '0 : wr_run_q + 1'b1;
        clr_run_d = disp_clr_n ? '0 : clr_run_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_run_q  <= '0;
            clr_run_q <= '0;
        end else begin
            wr_run_q  <= wr_run_d;
            clr_run_q <= clr_run_d;
        end
    end

    assert_addr_set_before_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disp_wr_n) |-> ($stable(disp_addr) && $stable(disp_data)));

    assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_wr_n) |-> (wr_run_q == CNT_W'(STRB_CYC)));

    assert_lines_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> ($stable(disp_addr) && $stable(disp_data)));

    assert_clear_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_clr_n) |-> (clr_run_q == CNT_W'(CLR_CYC)));

    assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_wr_n || !disp_clr_n) |-> !req_ready);

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && clr_valid) |=> (!disp_clr_n && disp_wr_n));

    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        disp_wr_n || disp_clr_n);

endmodule

// File: tb/sim_digit_load_sequencer.sv
`timescale 1ns/1ps
module sim_digit_load_sequencer;
    localparam int CLK_PERIOD = 25;   // 40 MHz
    // Expected counts at 40 MHz: 10ns->0.4->1, 90ns->3.6->4, 40ns->1.6->2, 1ms->40000
    localparam int E_SETUP = 1;
    localparam int E_STRB  = 4;
    localparam int E_HOLD  = 2;
    localparam int E_CLR   = 40000;
    localparam int WATCHDOG = 190000;

    logic clk = 0, rst_n = 0;
    logic wr_valid = 0, clr_valid = 0;
    logic [1:0] wr_digit = 0;
    logic [6:0] wr_char = 0;
    logic req_ready, disp_wr_n, disp_clr_n;
    logic [1:0] disp_addr;
    logic [6:0] disp_data;

    int total = 0, bad = 0, cyc = 0;
    bit run_chk = 0, done = 0;

    digit_load_sequencer #(.CLK_HZ(40_000_000)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_digit(wr_digit),
        .wr_char(wr_char), .clr_valid(clr_valid), .req_ready(req_ready),
        .disp_addr(disp_addr), .disp_data(disp_data),
        .disp_wr_n(disp_wr_n), .disp_clr_n(disp_clr_n));

    always #(CLK_PERIOD/2.0) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference: cycles elapsed since the accepting edge.
    bit m_busy; int m_kind; int m_t; logic [1:0] m_addr; logic [6:0] m_data;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_kind = 0; m_t = 0; m_addr = 0; m_data = 0;
        end else if (m_busy) begin
            m_t = m_t + 1;
            if (m_kind == 1 && m_t == E_SETUP + E_STRB + E_HOLD) m_busy = 0;
            if (m_kind == 2 && m_t == E_CLR) m_busy = 0;
        end else if (clr_valid) begin
            m_busy = 1; m_kind = 2; m_t = 0;
        end else if (wr_valid) begin
            m_busy = 1; m_kind = 1; m_t = 0; m_addr = wr_digit; m_data = wr_char;
        end
    end

    int wr_low = 0, clr_low = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n && run_chk) begin
            chk("R6 ready", req_ready, !m_busy);
            chk("R2/R8/R10 addr", disp_addr, m_addr);
            chk("R2/R8/R10 data", disp_data, m_data);
            chk("R2/R3/R4 wr_n", disp_wr_n,
                !(m_busy && m_kind == 1 && m_t >= E_SETUP && m_t < E_SETUP + E_STRB));
            chk("R5/R7 clr_n", disp_clr_n, !(m_busy && m_kind == 2));
            if (!disp_wr_n) wr_low++;
            else if (wr_low > 0) begin chk("R3/R9 strobe length", wr_low, E_STRB); wr_low = 0; end
            if (!disp_clr_n) clr_low++;
            else if (clr_low > 0) begin chk("R5/R9 clear length", clr_low, E_CLR); clr_low = 0; end
        end
        if (cyc > WATCHDOG && !done) begin
            done = 1; bad++; total++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_write(input logic [1:0] d, input logic [6:0] c);
        wr_valid = 1; wr_digit = d; wr_char = c;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 0;
    endtask

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ready", req_ready, 1);
        chk("R1 wr_n", disp_wr_n, 1);
        chk("R1 clr_n", disp_clr_n, 1);
        chk("R1 addr", disp_addr, 0);
        chk("R1 data", disp_data, 0);
        rst_n = 1; run_chk = 1;
        @(negedge clk);

        do_write(2'd0, 7'h41);               // R10 rightmost digit
        chk("R2 addr next cycle", disp_addr, 0);
        chk("R2 data next cycle", disp_data, 7'h41);
        chk("R6 busy", req_ready, 0);
        wait_idle();
        do_write(2'd3, 7'h7F);
        do_write(2'd1, 7'h00);               // back to back, waits for ready
        wait_idle();
        chk("R8 addr kept", disp_addr, 1);
        chk("R8 data kept", disp_data, 0);

        do_write(2'd2, 7'h55);
        wr_valid = 1; wr_digit = 2'd1; wr_char = 7'h22;   // offered while busy
        @(negedge clk);
        wr_valid = 0;
        wait_idle();
        chk("R6 ignored addr", disp_addr, 2);
        chk("R6 ignored data", disp_data, 7'h55);

        clr_valid = 1; wr_valid = 1; wr_digit = 2'd3; wr_char = 7'h11;  // both together
        @(negedge clk);
        clr_valid = 0;
        chk("R7 clear taken", disp_clr_n, 0);
        chk("R7 write not taken addr", disp_addr, 2);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 0;
        chk("R7 deferred write addr", disp_addr, 3);
        chk("R7 deferred write data", disp_data, 7'h11);
        wait_idle();

        clr_valid = 1;
        @(negedge clk);
        clr_valid = 0;
        chk("R5 clear alone", disp_clr_n, 0);
        wait_idle();
        repeat (3) @(negedge clk);
        chk("R8 idle wr_n", disp_wr_n, 1);
        chk("R8 idle clr_n", disp_clr_n, 1);
        chk("R8 idle addr", disp_addr, 3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule